// File: doc/BRIEF.md
# Relocatable Standby RAM Controller

This block is a bus slave that holds a 2-Kbyte static RAM array and a fixed 64-byte window of control registers. Software moves the array to any 2-Kbyte-aligned place in the address map by writing a base register. A configuration register picks the address spaces (program, data, or both) in which the array answers. It also holds a stop bit that freezes the array without losing its contents. A power-fail flag records a failure of the standby supply.

Each transfer is a one-cycle request that carries an address, a space qualifier, a size (byte, word or long), a direction and write data. A claimed transfer is acknowledged on the second cycle, with read data. A misaligned claimed transfer raises an error pulse in that cycle instead. Transfers that the block does not claim get no acknowledge and no error. Data is big-endian: the byte at the even address is the high byte of a word, and a long word is two consecutive words with the more significant word at the lower address.

Top module: `sram_reloc`

## Requirements
- R1: After reset, the configuration word (offset 0x00) reads 0x0300 and the base word (offset 0x04) reads 0x0000.
- R2: The register window is the 64 bytes at REG_BASE (default 0xFFFB00) and answers in both spaces. Offsets other than 0x00 and 0x04 read zero, including the test word at 0x02. Writes to them change nothing. Configuration bits other than 15, 11, 9 and 8 read zero.
- R3: The array answers at addresses whose bits [23:11] equal base word bits [15:3]. Address bits [10:0] select the byte. Moving the base keeps the contents at the same offsets.
- R4: Base word bit 0 enables the array. While it is 0, the array claims no access.
- R5: Configuration bit 9 lets the array answer program-space accesses (space=1). Bit 8 lets it answer data-space accesses (space=0). Both bits are 1 after reset.
- R6: While configuration bit 15 (stop) is 1, the array claims no access and keeps its contents. The registers stay accessible.
- R7: Size 0 is a byte, returned in rdata[7:0] and taken from wdata[7:0]. Size 1 is a word in rdata[15:0]. Size 2 is a long in rdata[31:0], with the lower-address word in bits [31:16]. Read data is zero in every cycle without a read acknowledge.
- R8: A claimed, aligned request in cycle N gives a one-cycle acknowledge in cycle N+1.
- R9: A claimed request is rejected if it is a word at an odd address, a long at an address not a multiple of 4, or size 3. It gets an error pulse in cycle N+1, no acknowledge, and no write.
- R10: Where the array window overlaps the register window, the registers answer and the array does not.
- R11: A pulse on pwr_fail sets configuration bit 11. A write with bit 11 at 0 clears it. A write with bit 11 at 1 leaves it unchanged.
- R12: An access that hits neither window gets neither an acknowledge nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transfer request, one cycle |
| addr | input | ADDR_W | Byte address |
| space | input | 1 | 1 = program space, 0 = data space |
| size | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 32 | Write data, right-aligned |
| pwr_fail | input | 1 | Standby power failure pulse |
| rdata | output | 32 | Read data, right-aligned |
| ack | output | 1 | Transfer acknowledge |
| err | output | 1 | Misaligned transfer error |

## Verification
The hardest case to reach from the ports is an array window that covers the register window. In that case the register decode must win, while the array still answers at the neighbouring addresses of the same 2-Kbyte page. The bench programs the base to the page that holds the registers. It then checks accesses just inside and just outside the 64-byte register block. Random traffic is steered towards the current window and the register block, so that stop, space selection and relocation come out of ordinary register writes and change while array data is live.

// File: rtl/sram_reloc_pkg.sv
`timescale 1ns/1ps
package sram_reloc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  // One 16-bit word location's share of a transfer.
  typedef struct packed {
    logic [1:0]  be;   // [1] high (even) byte, [0] low (odd) byte
    logic [15:0] d;
  } lane_t;

  function automatic logic misaligned(xfer_size_e sz, logic [1:0] a);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_WORD: return a[0];
      SZ_LONG: return a != 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  // first: this word is addressed directly; second: next word of a long.
  function automatic lane_t lane_for(logic first, logic second, logic b0,
                                     xfer_size_e sz, logic [31:0] wd);
    lane_t l;
    l = '0;
    if (first) begin
      case (sz)
        SZ_BYTE: begin l.be = b0 ? 2'b01 : 2'b10; l.d = {wd[7:0], wd[7:0]}; end
        SZ_WORD: begin l.be = 2'b11; l.d = wd[15:0]; end
        SZ_LONG: begin l.be = 2'b11; l.d = wd[31:16]; end
        default: l = '0;
      endcase
    end else if (second && sz == SZ_LONG) begin
      l.be = 2'b11;
      l.d  = wd[15:0];
    end
    return l;
  endfunction

  function automatic logic [15:0] merge16(logic [15:0] old, lane_t l);
    return {l.be[1] ? l.d[15:8] : old[15:8], l.be[0] ? l.d[7:0] : old[7:0]};
  endfunction

  function automatic logic [31:0] pack_read(xfer_size_e sz, logic b0,
                                            logic [15:0] w0, logic [15:0] w1);
    case (sz)
      SZ_BYTE: return {24'd0, b0 ? w0[7:0] : w0[15:8]};
      SZ_WORD: return {16'd0, w0};
      SZ_LONG: return {w0, w1};
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/sram_reloc_decode.sv
`timescale 1ns/1ps
module sram_reloc_decode
  import sram_reloc_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          OFF_W    = 11,
  parameter logic [23:0] REG_BASE = 24'hFFFB00
) (
  input  logic                    req,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    space,
  input  xfer_size_e              size,
  input  logic [ADDR_W-OFF_W-1:0] base_row,
  input  logic                    base_en,
  input  logic                    stop,
  input  logic                    spc_prg,
  input  logic                    spc_dat,
  output logic                    reg_hit,
  output logic                    arr_hit,
  output logic                    acc_ok,
  output logic                    acc_err,
  output logic [OFF_W-1:0]        arr_off,
  output logic [5:0]              reg_off
);
  logic win_hit, spc_ok, bad_align;

  assign reg_hit   = req && (addr[ADDR_W-1:6] == REG_BASE[ADDR_W-1:6]);
  assign win_hit   = req && base_en && (addr[ADDR_W-1:OFF_W] == base_row);
  assign spc_ok    = space ? spc_prg : spc_dat;
  assign arr_hit   = win_hit && spc_ok && !stop && !reg_hit;
  assign bad_align = misaligned(size, addr[1:0]);
  assign acc_ok    = (reg_hit || arr_hit) && !bad_align;
  assign acc_err   = (reg_hit || arr_hit) && bad_align;
  assign arr_off   = addr[OFF_W-1:0];
  assign reg_off   = addr[5:0];
endmodule

// File: rtl/sram_reloc_regs.sv
`timescale 1ns/1ps
module sram_reloc_regs
  import sram_reloc_pkg::*;
#(
  parameter int BASE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [5:0]        off,
  input  xfer_size_e        size,
  input  logic [31:0]       wdata,
  input  logic              pf_set,
  output logic              stop,
  output logic              spc_prg,
  output logic              spc_dat,
  output logic              pfail,
  output logic [BASE_W-1:0] base_row,
  output logic              base_en,
  output logic [31:0]       rdata
);
  localparam logic [4:0] CFG_IDX  = 5'd0;
  localparam logic [4:0] BASE_IDX = 5'd2;

  logic [15:0] cfg_word, base_word, cfg_new, base_new;
  logic [4:0]  widx, widx_nx;
  lane_t       cfg_ln, base_ln;

  assign cfg_word  = {stop, 3'b000, pfail, 1'b0, spc_prg, spc_dat, 8'h00};
  assign base_word = {base_row, {(15-BASE_W){1'b0}}, base_en};
  assign widx      = off[5:1];
  assign widx_nx   = off[5:1] + 5'd1;

  function automatic logic [15:0] word_at(logic [4:0] i, logic [15:0] c, logic [15:0] b);
    return (i == CFG_IDX) ? c : (i == BASE_IDX) ? b : 16'h0000;
  endfunction

  assign cfg_ln   = lane_for(widx == CFG_IDX,  widx_nx == CFG_IDX,  off[0], size, wdata);
  assign base_ln  = lane_for(widx == BASE_IDX, widx_nx == BASE_IDX, off[0], size, wdata);
  assign cfg_new  = merge16(cfg_word, cfg_ln);
  assign base_new = merge16(base_word, base_ln);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop     <= 1'b0;
      spc_prg  <= 1'b1;
      spc_dat  <= 1'b1;
      pfail    <= 1'b0;
      base_row <= '0;
      base_en  <= 1'b0;
    end else begin
      if (we) begin
        stop     <= cfg_new[15];
        spc_prg  <= cfg_new[9];
        spc_dat  <= cfg_new[8];
        base_row <= base_new[15 -: BASE_W];
        base_en  <= base_new[0];
      end
      pfail <= pf_set || (pfail && (!we || cfg_new[11]));
    end
  end

  assign rdata = pack_read(size, off[0], word_at(widx, cfg_word, base_word),
                           word_at(widx_nx, cfg_word, base_word));
endmodule

// File: rtl/sram_reloc_array.sv
`timescale 1ns/1ps
module sram_reloc_array
  import sram_reloc_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OFF_W-1:0] off,
  input  xfer_size_e       size,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  localparam int ROW_W = OFF_W - 2;
  localparam int ROWS  = 2 ** ROW_W;

  logic [ROW_W-1:0] row;
  logic             bsel;
  logic [15:0]      bank_rd [2];

  assign row  = off[OFF_W-1:2];
  assign bsel = off[1];

  // Two word banks: a long word writes one row of both in the same cycle.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [15:0] mem [ROWS];
    lane_t       ln;
    assign ln = lane_for(bsel == 1'(b), (b == 1) && !bsel, off[0], size, wdata);
    always_ff @(posedge clk) begin
      if (we && ln.be[1]) mem[row][15:8] <= ln.d[15:8];
      if (we && ln.be[0]) mem[row][7:0]  <= ln.d[7:0];
    end
    assign bank_rd[b] = mem[row];
  end

  assign rdata = pack_read(size, off[0], bsel ? bank_rd[1] : bank_rd[0], bank_rd[1]);
endmodule

// File: rtl/sram_reloc.sv
`timescale 1ns/1ps
module sram_reloc
  import sram_reloc_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          ARR_BYTES = 2048,
  parameter logic [23:0] REG_BASE  = 24'hFFFB00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              space,
  input  logic [1:0]        size,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic              pwr_fail,
  output logic [31:0]       rdata,
  output logic              ack,
  output logic              err
);
  localparam int OFF_W  = $clog2(ARR_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;

  xfer_size_e        sz;
  logic              reg_hit, arr_hit, acc_ok, acc_err;
  logic [OFF_W-1:0]  arr_off;
  logic [5:0]        reg_off;
  logic              stop, spc_prg, spc_dat, pfail, base_en;
  logic [BASE_W-1:0] base_row;
  logic [31:0]       reg_rd, arr_rd;
  logic              reg_we, arr_we;

  assign sz     = xfer_size_e'(size);
  assign reg_we = acc_ok && reg_hit && wr;
  assign arr_we = acc_ok && arr_hit && wr;

  sram_reloc_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .REG_BASE(REG_BASE)) u_dec (
    .req, .addr, .space, .size(sz), .base_row, .base_en, .stop, .spc_prg, .spc_dat,
    .reg_hit, .arr_hit, .acc_ok, .acc_err, .arr_off, .reg_off
  );

  sram_reloc_regs #(.BASE_W(BASE_W)) u_regs (
    .clk, .rst_n, .we(reg_we), .off(reg_off), .size(sz), .wdata, .pf_set(pwr_fail),
    .stop, .spc_prg, .spc_dat, .pfail, .base_row, .base_en, .rdata(reg_rd)
  );

  sram_reloc_array #(.OFF_W(OFF_W)) u_arr (
    .clk, .we(arr_we), .off(arr_off), .size(sz), .wdata, .rdata(arr_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= acc_ok;
      err   <= acc_err;
      rdata <= (acc_ok && !wr) ? (reg_hit ? reg_rd : arr_rd) : 32'd0;
    end
  end
endmodule

// File: rtl/sram_reloc_chk.sv
`timescale 1ns/1ps
module sram_reloc_chk #(
  parameter int          ADDR_W   = 24,
  parameter logic [23:0] REG_BASE = 24'hFFFB00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic              pwr_fail,
  input logic              ack,
  input logic              err,
  input logic [31:0]       rdata,
  input logic              stop,
  input logic              base_en,
  input logic              pfail,
  input logic              reg_hit
);
  logic reg_aligned;
  assign reg_aligned = req && (addr[ADDR_W-1:6] == REG_BASE[ADDR_W-1:6]) &&
                       ((size == 2'd0) || (size == 2'd1 && !addr[0]) ||
                        (size == 2'd2 && addr[1:0] == 2'b00));

  // R8
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));
  // R9
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && err));
  // R10
  reg_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_aligned |=> ack);
  // R6
  stop_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && stop && !reg_hit) |=> (!ack && !err));
  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !base_en && !reg_hit) |=> (!ack && !err));
  // R11
  pfail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> pfail);
  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (rdata == 32'd0));
endmodule

bind sram_reloc sram_reloc_chk #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) u_chk (
  .clk, .rst_n, .req, .addr, .size, .pwr_fail, .ack, .err, .rdata,
  .stop, .base_en, .pfail, .reg_hit
);

// File: tb/sram_reloc_bench.sv
`timescale 1ns/1ps
module sram_reloc_bench;
  localparam logic [23:0] REGB = 24'hFFFB00;

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, space = 1'b0, wr = 1'b0, pwr_fail = 1'b0;
  logic [23:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0, rdata;
  logic        ack, err;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  // bench model of the programmer-visible state
  logic [7:0]  mem_m [2048];
  logic        stop_m, pfail_m, en_m;
  logic [1:0]  spc_m;          // [1] program, [0] data
  logic [12:0] brow_m;

  sram_reloc u_sram_reloc (.clk, .rst_n, .req, .addr, .space, .size, .wr, .wdata,
                           .pwr_fail, .rdata, .ack, .err);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] reg_byte(logic [5:0] o);
    logic [15:0] w;
    if (o[5:1] == 5'd0)      w = {stop_m, 3'b0, pfail_m, 1'b0, spc_m, 8'h00};
    else if (o[5:1] == 5'd2) w = {brow_m, 2'b00, en_m};
    else                     w = 16'h0000;
    return o[0] ? w[7:0] : w[15:8];
  endfunction

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic xfer(logic [23:0] a, logic sp, logic [1:0] sz, logic w,
                      logic [31:0] wd, string tag, output logic [31:0] rd);
    logic        rh, ah, mis, e_ack, e_err;
    logic [31:0] e_rd;
    int          n;
    n   = nbytes(sz);
    rh  = (a[23:6] == REGB[23:6]);
    ah  = !rh && en_m && (a[23:11] == brow_m) && (sp ? spc_m[1] : spc_m[0]) && !stop_m;
    mis = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00);
    e_ack = (rh || ah) && !mis;
    e_err = (rh || ah) && mis;
    e_rd  = 32'd0;
    if (e_ack && !w)
      for (int i = 0; i < n; i++)
        e_rd = (e_rd << 8) | 32'(rh ? reg_byte(a[5:0] + 6'(i)) : mem_m[a[10:0] + 11'(i)]);
    @(negedge clk);
    req = 1'b1; addr = a; space = sp; size = sz; wr = w; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    check(ack == e_ack, tag, "ack", 32'(ack), 32'(e_ack));
    check(err == e_err, tag, "err", 32'(err), 32'(e_err));
    check(rdata === e_rd, tag, "rdata", rdata, e_rd);
    rd = rdata;
    if (e_ack && w)
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        b = 8'(wd >> (8 * (n - 1 - i)));
        if (!rh) mem_m[a[10:0] + 11'(i)] = b;
        else begin
          case (6'(a[5:0] + 6'(i)))
            6'd0: begin stop_m = b[7]; spc_m = b[1:0]; if (!b[3]) pfail_m = 1'b0; end
            6'd4: brow_m[12:5] = b;
            6'd5: begin brow_m[4:0] = b[7:3]; en_m = b[0]; end
            default: ;
          endcase
        end
      end
  endtask

  task automatic set_base(logic [23:0] base, logic en);
    logic [31:0] d;
    xfer(REGB + 24'h4, 1'b0, 2'd1, 1'b1, {16'h0, base[23:11], 2'b00, en}, "R3", d);
  endtask

  task automatic set_cfg(logic st, logic [1:0] spc);
    logic [31:0] d;
    xfer(REGB, 1'b0, 2'd1, 1'b1, {16'h0, st, 3'b0, 1'b1, 1'b0, spc, 8'h00}, "R6", d);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    stop_m = 0; pfail_m = 0; en_m = 0; spc_m = 2'b11; brow_m = '0;
    for (int i = 0; i < 2048; i++) mem_m[i] = 'x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values, R4 array disabled at reset
    xfer(REGB, 1'b0, 2'd1, 1'b0, 0, "R1", d);
    check(d == 32'h0300, "R1", "cfg reset", d, 32'h0300);
    xfer(REGB + 24'h4, 1'b1, 2'd1, 1'b0, 0, "R1", d);
    xfer(24'h000010, 1'b0, 2'd1, 1'b0, 0, "R4", d);

    // fill the array with long writes at base 0x123800 (R3, R7)
    set_base(24'h123800, 1'b1);
    for (int i = 0; i < 512; i++)
      xfer(24'h123800 + 24'(4 * i), 1'b0, 2'd2, 1'b1, $urandom, "R7", d);
    xfer(24'h123800, 1'b0, 2'd1, 1'b1, 32'h0000A1B2, "R7", d);
    xfer(24'h123803, 1'b1, 2'd0, 1'b1, 32'h000000C3, "R7", d);
    xfer(24'h123800, 1'b0, 2'd2, 1'b0, 0, "R7", d);
    xfer(24'h123801, 1'b0, 2'd0, 1'b0, 0, "R7", d);
    xfer(24'h123FFC, 1'b0, 2'd2, 1'b0, 0, "R7", d);

    // R3 relocation keeps offsets, R12 old page silent
    set_base(24'h004000, 1'b1);
    xfer(24'h004000, 1'b0, 2'd2, 1'b0, 0, "R3", d);
    xfer(24'h123800, 1'b0, 2'd2, 1'b0, 0, "R12", d);
    xfer(24'h7FFFFE, 1'b0, 2'd1, 1'b0, 0, "R12", d);

    // R4 disable bit
    set_base(24'h004000, 1'b0);
    xfer(24'h004000, 1'b0, 2'd1, 1'b0, 0, "R4", d);
    set_base(24'h004000, 1'b1);

    // R6 stop gates the array, registers live, contents kept
    set_cfg(1'b1, 2'b11);
    xfer(24'h004010, 1'b0, 2'd1, 1'b1, 32'h5555, "R6", d);
    xfer(24'h004010, 1'b0, 2'd1, 1'b0, 0, "R6", d);
    xfer(REGB, 1'b0, 2'd1, 1'b0, 0, "R6", d);
    set_cfg(1'b0, 2'b11);
    xfer(24'h004010, 1'b0, 2'd2, 1'b0, 0, "R6", d);

    // R5 space selection
    set_cfg(1'b0, 2'b01);
    xfer(24'h004020, 1'b1, 2'd1, 1'b0, 0, "R5", d);
    xfer(24'h004020, 1'b0, 2'd1, 1'b0, 0, "R5", d);
    set_cfg(1'b0, 2'b10);
    xfer(24'h004020, 1'b1, 2'd1, 1'b0, 0, "R5", d);
    xfer(24'h004020, 1'b0, 2'd1, 1'b0, 0, "R5", d);
    set_cfg(1'b0, 2'b00);
    xfer(24'h004020, 1'b1, 2'd1, 1'b0, 0, "R5", d);
    set_cfg(1'b0, 2'b11);

    // R9 misaligned and reserved size: error, no write
    xfer(24'h004031, 1'b0, 2'd1, 1'b1, 32'hFFFF, "R9", d);
    xfer(24'h004032, 1'b0, 2'd2, 1'b1, 32'hFFFFFFFF, "R9", d);
    xfer(24'h004030, 1'b0, 2'd3, 1'b1, 32'hFFFFFFFF, "R9", d);
    xfer(REGB + 24'h1, 1'b0, 2'd1, 1'b0, 0, "R9", d);
    xfer(24'h004030, 1'b0, 2'd2, 1'b0, 0, "R9", d);

    // R10 window over the register page
    set_base(24'hFFF800, 1'b1);
    xfer(REGB + 24'h40, 1'b0, 2'd2, 1'b1, 32'hDEADBEEF, "R10", d);
    xfer(REGB + 24'h40, 1'b0, 2'd2, 1'b0, 0, "R10", d);
    xfer(REGB + 24'h10, 1'b0, 2'd2, 1'b1, 32'h12345678, "R10", d);
    xfer(REGB + 24'h10, 1'b0, 2'd2, 1'b0, 0, "R10", d);
    xfer(REGB - 24'h2, 1'b1, 2'd1, 1'b0, 0, "R10", d);

    // R2 unimplemented locations and test word
    xfer(REGB + 24'h2, 1'b0, 2'd1, 1'b1, 32'hFFFF, "R2", d);
    xfer(REGB, 1'b1, 2'd2, 1'b0, 0, "R2", d);
    xfer(REGB + 24'h3C, 1'b0, 2'd2, 1'b1, 32'hFFFFFFFF, "R2", d);
    xfer(REGB + 24'h3C, 1'b0, 2'd2, 1'b0, 0, "R2", d);
    xfer(REGB, 1'b0, 2'd0, 1'b1, 32'h000000FF, "R2", d);
    xfer(REGB + 24'h1, 1'b0, 2'd0, 1'b0, 0, "R2", d);

    // R11 power fail flag
    @(negedge clk); pwr_fail = 1'b1; pfail_m = 1'b1;
    @(negedge clk); pwr_fail = 1'b0;
    xfer(REGB, 1'b0, 2'd1, 1'b0, 0, "R11", d);
    xfer(REGB, 1'b0, 2'd0, 1'b1, 32'h08, "R11", d);
    xfer(REGB, 1'b0, 2'd1, 1'b0, 0, "R11", d);
    xfer(REGB, 1'b0, 2'd1, 1'b1, 32'h0300, "R11", d);
    xfer(REGB, 1'b0, 2'd1, 1'b0, 0, "R11", d);

    // R8 acknowledge lasts one cycle
    xfer(REGB, 1'b0, 2'd1, 1'b0, 0, "R8", d);
    @(negedge clk);
    check(ack == 1'b0, "R8", "ack width", 32'(ack), 32'd0);

    // constrained random traffic
    set_base(24'h2A0800, 1'b1);
    for (int k = 0; k < 2000; k++) begin
      logic [23:0] a;
      logic [31:0] r;
      int          pick;
      pick = $urandom_range(0, 9);
      if (pick < 6)      a = {brow_m, 11'($urandom)};
      else if (pick < 8) a = {REGB[23:6], 6'($urandom) & 6'h07};
      else               a = 24'($urandom);
      r = $urandom;
      if (a[23:6] == REGB[23:6] && a[5:0] < 6'd2) r = r & 32'hFFFF7FFF;
      xfer(a, 1'($urandom), 2'($urandom_range(0, 3)), 1'($urandom), r, "R7", d);
      if (!en_m || stop_m || spc_m == 2'b00) set_base({brow_m, 11'h0}, 1'b1);
      if (stop_m || spc_m != 2'b11) set_cfg(1'b0, 2'b11);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule